// File: doc/BRIEF.md
# Single-Slope Up-Count Timer with PWM and Toggle Output

This block is a timer with one output channel. A free-running up-counter advances once per prescaler tick, where the prescaler divides the clock by a power of two. The counter runs from zero to a programmable ceiling and then wraps to zero, so one period is ceiling+1 ticks. The channel can drive its pin in two ways:

- **PWM mode.** The pin is high for a programmed number of ticks at the start of every period.
- **Compare mode.** The pin is changed by configurable actions at compare match and at wrap. Choosing "toggle at wrap" gives a square wave for frequency generation.

Software writes the ceiling and the compare value into shadow buffers. While the timer runs, the buffers move into the active registers only when the counter wraps, so a period in progress never changes shape. While the timer is stopped they load at once.

Two small state machines control the block. The run machine has the states `RS_IDLE` and `RS_RUN`:
- `RS_IDLE` → `RS_RUN` when the enable bit is set.
- `RS_RUN` → `RS_IDLE` when the enable bit is cleared.

In `RS_IDLE` the prescaler phase and the counter are held at zero, and the active registers follow the buffers.

The channel machine has the states `CH_LOW` and `CH_HIGH`, and its state is the pin level:
- In PWM mode it moves on every tick to the level that the new count calls for.
- In compare mode it moves only when a wrap action or a match action fires.
- In `RS_IDLE` with PWM selected, it is preset to the level that count 0 will produce.

Top module: `upcount_pwm_timer`

## Requirements
- R1: While running, the count takes the values 0 to TOP and then returns to 0, so one period lasts TOP+1 ticks.
- R2: The count advances once every 2^DIV clock cycles, with DIV a 4-bit exponent. The prescaler phase restarts whenever the timer is stopped, so the first tick comes 2^DIV cycles after the run state is entered.
- R3: In PWM mode the pin is high while the count is below CMP and low otherwise. The pin is therefore high for CMP ticks from the start of each period.
- R4: In PWM mode a CMP of 0 holds the pin low, and a CMP of TOP+1 or more holds it high. CMP is one bit wider than the count.
- R5: While running, writes to TOP and CMP go to buffers and take effect only at the next wrap. The period in progress keeps its old high time and length.
- R6: While stopped, the buffers load into the active registers every cycle and the count is held at 0. In PWM mode the pin then shows the level of count 0: high if CMP is nonzero, low otherwise.
- R7: In compare mode with the wrap action set to toggle, the pin toggles at each wrap. This gives a square wave of period 2^(DIV+1)·(TOP+1) clock cycles.
- R8: In compare mode an action field is decoded as 0 = none, 1 = toggle, 2 = clear, 3 = set. The match action applies on the tick where the new count equals CMP, and the wrap action applies on the tick where the count returns to 0. If both fire on the same tick and the match action is not "none", only the match action applies.
- R9: In PWM mode both action fields have no effect on the pin.
- R10: After synchronous reset the pin is low, the timer is stopped, and all buffers and fields are 0.
- R11: Registers are written by address with the write enable high: 0 = TOP, 1 = CMP, 2 = DIV (bits 3:0), 3 = mode, 4 = enable (bit 0). The mode register holds bit 0 = PWM select, bits 2:1 = wrap action, and bits 4:3 = match action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W+1 | Register write data |
| wave_o | output | 1 | Channel output pin |

## Verification
Two events can land on the same tick:
- **Compare match and wrap.** A CMP of 0 in compare mode, with a wrap action of set and a match action of clear, makes both fire on every period boundary. The pin must stay low, because the match action wins.
- **Buffer load and wrap.** A new CMP or TOP is written just after a rising edge of the pin. The measured high and low run lengths must keep their old values for the rest of that period and change only from the next period on.

A scoreboard of expected run lengths, started at a rising edge, judges both cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RUN  = 1'b1
    } run_state_e;

    typedef enum logic {
        CH_LOW  = 1'b0,
        CH_HIGH = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } pin_action_e;

    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] REG_TOP  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CMP  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_DIV  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_MODE = 3'd3;
    localparam logic [ADDR_W-1:0] REG_EN   = 3'd4;
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned PRESC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W:0]    wr_data,
    output logic [CNT_W-1:0]  top_buf,
    output logic [CNT_W:0]    cmp_buf,
    output logic [PRESC_W-1:0] div_exp,
    output logic              pwm_sel,
    output pin_action_e       ovf_act,
    output pin_action_e       match_act,
    output logic              enable
);
    always_ff @(posedge clk) begin
        if (rst) begin
            top_buf   <= '0;
            cmp_buf   <= '0;
            div_exp   <= '0;
            pwm_sel   <= 1'b0;
            ovf_act   <= ACT_NONE;
            match_act <= ACT_NONE;
            enable    <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_TOP:  top_buf <= wr_data[CNT_W-1:0];
                REG_CMP:  cmp_buf <= wr_data;
                REG_DIV:  div_exp <= wr_data[PRESC_W-1:0];
                REG_MODE: begin
                    pwm_sel   <= wr_data[0];
                    ovf_act   <= pin_action_e'(wr_data[2:1]);
                    match_act <= pin_action_e'(wr_data[4:3]);
                end
                REG_EN:   enable <= wr_data[0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned PRESC_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [PRESC_W-1:0] div_exp,
    output logic               tick
);
    localparam int unsigned DIV_W = (1 << PRESC_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;

    // thermometer mask: the low div_exp bits set
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(div_exp));
        end
    end

    always_comb tick = !restart && ((phase_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart) phase_q <= '0;
        else                phase_q <= phase_q + 1'b1;
    end

    // R2: with a divider above one, ticks never come back to back
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && div_exp != '0) |=> (!tick || div_exp == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_buf,
    input  logic [CNT_W:0]   cmp_buf,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W:0]   cmp_next,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_q;
    logic [CNT_W:0]   cmp_q;

    always_comb begin
        wrap     = tick && (cnt_q == top_q);
        cnt_next = wrap ? '0 : cnt_q + 1'b1;
        cmp_next = (idle || wrap) ? cmp_buf : cmp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            top_q <= '0;
            cmp_q <= '0;
        end else if (idle) begin
            cnt_q <= '0;
            top_q <= top_buf;
            cmp_q <= cmp_buf;
        end else if (tick) begin
            cnt_q <= cnt_next;
            if (wrap) begin
                top_q <= top_buf;
                cmp_q <= cmp_buf;
            end
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        !idle |-> (cnt_q <= top_q));

    assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == '0));

    assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!idle && !wrap) |=> $stable(cmp_q));

    assert_top_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!idle && !wrap) |=> $stable(top_q));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             tick,
    input  logic             wrap,
    input  logic             pwm_sel,
    input  pin_action_e      ovf_act,
    input  pin_action_e      match_act,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [CNT_W:0]   cmp_next,
    output logic             pin_o
);
    ch_state_e state_q, state_d;
    logic      match;

    function automatic ch_state_e apply_act(ch_state_e cur, pin_action_e act);
        ch_state_e res;
        unique case (act)
            ACT_NONE:   res = cur;
            ACT_TOGGLE: res = (cur == CH_HIGH) ? CH_LOW : CH_HIGH;
            ACT_CLEAR:  res = CH_LOW;
            ACT_SET:    res = CH_HIGH;
        endcase
        return res;
    endfunction

    always_comb match = tick && ({1'b0, cnt_next} == cmp_next);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (idle) begin
            if (pwm_sel) state_d = (cmp_next != '0) ? CH_HIGH : CH_LOW;
        end else if (tick) begin
            if (pwm_sel) begin
                state_d = ({1'b0, cnt_next} < cmp_next) ? CH_HIGH : CH_LOW;
            end else if (match && match_act != ACT_NONE) begin
                state_d = apply_act(state_q, match_act);
            end else if (wrap) begin
                state_d = apply_act(state_q, ovf_act);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_LOW;
        else     state_q <= state_d;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            CH_LOW:  pin_o = 1'b0;
            CH_HIGH: pin_o = 1'b1;
        endcase
    end

    assert_quiet_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
        (!idle && !tick) |=> $stable(pin_o));

    assert_zero_cmp_low_R4: assert property (@(posedge clk) disable iff (rst)
        (pwm_sel && tick && cmp_next == '0) |=> !pin_o);

    assert_pwm_ignores_actions_R9: assert property (@(posedge clk) disable iff (rst)
        (pwm_sel && tick && ({1'b0, cnt_next} >= cmp_next)) |=> !pin_o);
endmodule

// File: rtl/upcount_pwm_timer.sv
module upcount_pwm_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned PRESC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W:0]    wr_data,
    output logic              wave_o
);
    logic [CNT_W-1:0]   top_buf;
    logic [CNT_W:0]     cmp_buf;
    logic [PRESC_W-1:0] div_exp;
    logic               pwm_sel;
    pin_action_e        ovf_act;
    pin_action_e        match_act;
    logic               enable;
    logic               tick;
    logic               wrap;
    logic [CNT_W-1:0]   cnt_next;
    logic [CNT_W:0]     cmp_next;
    logic               idle;
    run_state_e         rs_q, rs_d;

    // run state register
    always_ff @(posedge clk) begin
        if (rst) rs_q <= RS_IDLE;
        else     rs_q <= rs_d;
    end

    // run state transitions
    always_comb begin
        unique case (rs_q)
            RS_IDLE: rs_d = enable ? RS_RUN  : RS_IDLE;
            RS_RUN:  rs_d = enable ? RS_RUN  : RS_IDLE;
        endcase
    end

    always_comb idle = (rs_q == RS_IDLE);

    tmr_regfile #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .top_buf(top_buf), .cmp_buf(cmp_buf), .div_exp(div_exp), .pwm_sel(pwm_sel),
        .ovf_act(ovf_act), .match_act(match_act), .enable(enable)
    );

    tmr_prescaler #(.PRESC_W(PRESC_W)) presc_i (
        .clk(clk), .rst(rst), .restart(idle), .div_exp(div_exp), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .idle(idle), .tick(tick), .top_buf(top_buf),
        .cmp_buf(cmp_buf), .cnt_next(cnt_next), .cmp_next(cmp_next), .wrap(wrap)
    );

    tmr_channel #(.CNT_W(CNT_W)) chan_i (
        .clk(clk), .rst(rst), .idle(idle), .tick(tick), .wrap(wrap),
        .pwm_sel(pwm_sel), .ovf_act(ovf_act), .match_act(match_act),
        .cnt_next(cnt_next), .cmp_next(cmp_next), .pin_o(wave_o)
    );

    assert_stop_to_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (rs_q == RS_IDLE));

    assert_reset_low_R10: assert property (@(posedge clk)
        rst |=> !wave_o);
endmodule

// File: tb/upcount_pwm_timer_tb_top.sv
module upcount_pwm_timer_tb_top;
    timeunit 1ns;
    timeprecision 1ps;
    import tmr_pkg::*;

    localparam int CNT_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W:0]    wr_data = '0;
    logic              wave_o;

    int    n_checks = 0;
    int    n_errs   = 0;
    int    exp_q[$];
    string req_q[$];
    int    mon_phase = 0;   // 0 off, 1 wait for rise, 2 measuring
    int    run_len   = 0;
    logic  prev_pin  = 1'b0;

    always #10 clk = ~clk;

    upcount_pwm_timer #(.CNT_W(CNT_W), .PRESC_W(4)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: measures run lengths from a rising edge and pops expectations
    always @(negedge clk) begin
        if (rst) begin
            run_len  = 0;
            prev_pin = wave_o;
        end else begin
            if (wave_o !== prev_pin) begin
                if (mon_phase == 1 && wave_o === 1'b1) begin
                    mon_phase = 2;
                    run_len   = 1;
                end else begin
                    if (mon_phase == 2 && exp_q.size() > 0) begin
                        int    e;
                        string r;
                        e = exp_q.pop_front();
                        r = req_q.pop_front();
                        chk(run_len == e, r, run_len, e);
                    end
                    run_len = 1;
                end
            end else begin
                run_len++;
            end
            prev_pin = wave_o;
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d[CNT_W:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic push_runs(input string req, input int hi, input int lo, input int reps);
        for (int i = 0; i < reps; i++) begin
            exp_q.push_back(hi); req_q.push_back(req);
            exp_q.push_back(lo); req_q.push_back(req);
        end
    endtask

    task automatic arm();
        @(posedge clk);
        #1 mon_phase = 1;
    endtask

    task automatic drain(input string req, input int limit);
        int n = 0;
        while (exp_q.size() > 0 && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (exp_q.size() > 0) begin
            chk(1'b0, {req, " runs not seen"}, exp_q.size(), 0);
            exp_q.delete();
            req_q.delete();
        end
        mon_phase = 0;
    endtask

    task automatic wait_level(input logic v);
        @(negedge clk);
        while (wave_o !== v) @(negedge clk);
    endtask

    task automatic steady(input logic v, input int cycles, input string req);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (wave_o !== v) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wave_o === 1'b0, "R10 reset level", int'(wave_o), 0);

        // basic PWM: TOP 9, CMP 3, divide by 1
        wr(REG_TOP, 9);
        wr(REG_CMP, 3);
        wr(REG_DIV, 0);
        wr(REG_MODE, 1);
        wr(REG_EN, 1);
        idle_cycles(25);
        push_runs("R1 R3 R11 pwm runs", 3, 7, 2);
        arm();
        drain("R3", 200);

        // CMP buffered: written just after a rise
        push_runs("R5 cmp buffered", 3, 7, 1);
        push_runs("R5 cmp applied", 6, 4, 2);
        arm();
        wait_level(1'b0);
        wait_level(1'b1);
        wr(REG_CMP, 6);
        drain("R5", 200);

        // TOP buffered: new TOP 5 makes CMP 6 a full-high value
        push_runs("R5 top buffered", 6, 4, 1);
        arm();
        wait_level(1'b0);
        wait_level(1'b1);
        wr(REG_TOP, 5);
        drain("R5", 200);
        steady(1'b1, 30, "R4 cmp above top stays high");

        // CMP 0 holds low
        wr(REG_CMP, 0);
        idle_cycles(20);
        steady(1'b0, 30, "R4 cmp zero stays low");

        // prescaler divide by 4
        wr(REG_DIV, 2);
        wr(REG_TOP, 4);
        wr(REG_CMP, 2);
        idle_cycles(60);
        push_runs("R2 prescaled pwm", 8, 12, 2);
        arm();
        drain("R2", 400);

        // action fields ignored in PWM mode: wrap=set, match=clear
        wr(REG_MODE, 23);
        idle_cycles(40);
        push_runs("R9 actions ignored", 8, 12, 2);
        arm();
        drain("R9", 400);

        // frequency generation: toggle on wrap, DIV 1, TOP 5
        wr(REG_MODE, 2);
        wr(REG_DIV, 1);
        wr(REG_TOP, 5);
        idle_cycles(60);
        push_runs("R7 square wave", 12, 12, 2);
        arm();
        drain("R7", 400);

        // compare mode: toggle on match only
        wr(REG_MODE, 8);
        wr(REG_DIV, 0);
        wr(REG_TOP, 9);
        wr(REG_CMP, 2);
        idle_cycles(40);
        push_runs("R8 match toggle", 10, 10, 2);
        arm();
        drain("R8", 400);

        // match and wrap on the same tick: wrap=set, match=clear, CMP 0
        wr(REG_MODE, 22);
        wr(REG_TOP, 7);
        wr(REG_CMP, 0);
        idle_cycles(40);
        steady(1'b0, 30, "R8 match wins over wrap");

        // stopped: PWM preset level follows the buffer at once
        wr(REG_EN, 0);
        wr(REG_MODE, 1);
        wr(REG_CMP, 3);
        @(negedge clk);
        chk(wave_o === 1'b1, "R6 stopped preset high", int'(wave_o), 1);
        wr(REG_CMP, 0);
        @(negedge clk);
        chk(wave_o === 1'b0, "R6 stopped preset low", int'(wave_o), 0);

        // prescaler restart and immediate load: DIV 3, TOP 1, CMP 1
        wr(REG_DIV, 3);
        wr(REG_TOP, 1);
        wr(REG_CMP, 1);
        idle_cycles(3);
        wr(REG_EN, 1);
        n = 0;
        while (wave_o === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == 9, "R2 first tick after enable", n, 9);
        n = 0;
        while (wave_o === 1'b0 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == 8, "R6 top loaded while stopped", n, 8);

        summary();
        $finish;
    end
endmodule